// File: doc/BRIEF.md
# Signed ALU with Flag Register and Condition Evaluator

This block is the arithmetic core of a small 32-bit processor. It combines two register operands with one of four operations: add, subtract, bitwise AND and bitwise XOR. It keeps three status flags that record the outcome of the last flag-setting operation: zero, sign and signed overflow. There is no carry flag, and every value is treated as a two's-complement signed number.

A 4-bit condition selector is compared against the stored flags. The block reports whether the selected condition currently holds. The sequencer uses this one answer both to decide a conditional branch and to decide whether a conditional register copy takes place.

The result is purely combinational. The flags register is written on a rising clock edge, and only when the flag-load input is high. Address and stack-pointer arithmetic can therefore share the adder: the sequencer simply holds flag-load low for those operations, and the flags stay as they were.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn` = 0 the result is `opnd_b + opnd_a`, modulo 2^32.
- R2: With `alu_fn` = 1 the result is `opnd_b - opnd_a`, modulo 2^32.
- R3: With `alu_fn` = 2 the result is `opnd_b & opnd_a`; with `alu_fn` = 3 it is `opnd_b ^ opnd_a`.
- R4: While `rst` is sampled high at a rising edge, the flags become zf=1, sf=0, of=0 after that edge.
- R5: When `cc_load` is high at a rising edge, after that edge zf is 1 exactly when the result was zero, and sf equals bit 31 of the result.
- R6: For an add with `cc_load` high, of becomes 1 exactly when both operands have the same sign and the result's sign differs from it.
- R7: For a subtract with `cc_load` high, of becomes 1 exactly when the operand signs differ and the result's sign differs from that of `opnd_b`.
- R8: For AND or XOR with `cc_load` high, of becomes 0.
- R9: When `cc_load` is low at an edge, zf, sf and of keep their values, while the result still follows the operands.
- R10: `cond_fn` 0 (always) is true. Code 3 (equal) is true when zf=1. Code 4 (not equal) is true when zf=0.
- R11: With lt = sf XOR of: code 2 (less) is lt, code 1 (less-or-equal) is lt OR zf, code 5 (greater-or-equal) is NOT lt, and code 6 (greater) is NOT (lt OR zf).
- R12: `cond_fn` values 7 to 15 give `cond_true` = 0.
- R13: `cond_true` follows `cond_fn` and the stored flags combinationally. After an edge that loads new flags, it reflects them without any further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| alu_fn | input | 2 | Operation select: 0 add, 1 sub, 2 and, 3 xor |
| opnd_a | input | 32 | First operand (rA value) |
| opnd_b | input | 32 | Second operand (rB value) |
| cc_load | input | 1 | Load flags from this operation at the next edge |
| cond_fn | input | 4 | Condition select, 0..6 valid |
| result | output | 32 | Operation result |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Signed overflow flag |
| cond_true | output | 1 | Selected condition holds on the current flags |

## Verification
The results arrive at three different times:
- `result` depends only on the operands and `alu_fn`, so it is due in the same cycle they are applied.
- The flags are due one rising edge after an operation presented with `cc_load` high.
- `cond_true` is due as soon as `cond_fn` or the stored flags change.

The bench therefore drives inputs at the falling edge. It checks `result` and `cond_true` 1 ns after driving them, and it checks the flags 1 ns after the following rising edge. Condition codes are swept over all sixteen values for several flag combinations that are built by real operations.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int DATA_W = 32;
    localparam int FN_W   = 2;
    localparam int COND_W = 4;

    typedef enum logic [FN_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    localparam logic [COND_W-1:0] CN_ALWAYS = 4'd0;
    localparam logic [COND_W-1:0] CN_LE     = 4'd1;
    localparam logic [COND_W-1:0] CN_LT     = 4'd2;
    localparam logic [COND_W-1:0] CN_EQ     = 4'd3;
    localparam logic [COND_W-1:0] CN_NE     = 4'd4;
    localparam logic [COND_W-1:0] CN_GE     = 4'd5;
    localparam logic [COND_W-1:0] CN_GT     = 4'd6;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

    // signed "less than" outcome of the last flag-setting operation
    function automatic logic signed_less(input flags_t f);
        return f.sf ^ f.of;
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output flags_t         nflags
);
    localparam int MSB = W - 1;

    logic           is_sub;
    logic [W-1:0]   a_eff;
    logic [W-1:0]   sum;
    logic           arith_ovf;

    // one adder serves add and subtract: b + ~a + 1 for subtract
    assign is_sub = (op == OP_SUB);
    assign a_eff  = is_sub ? ~a : a;
    assign sum    = b + a_eff + {{(W-1){1'b0}}, is_sub};

    // overflow when effective addends agree in sign and the sum does not
    assign arith_ovf = (a_eff[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:  res = sum;
            OP_AND:  res = b & a;
            OP_XOR:  res = b ^ a;
            default: res = '0;
        endcase
    end

    always_comb begin
        nflags.zf = (res == '0);
        nflags.sf = res[MSB];
        nflags.of = (op == OP_ADD || op == OP_SUB) ? arith_ovf : 1'b0;
    end

endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import alu_cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_RESET;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import alu_cc_pkg::*;
(
    input  flags_t             f,
    input  logic [COND_W-1:0]  sel,
    output logic               hit
);
    logic lt;
    logic le;

    assign lt = signed_less(f);
    assign le = lt | f.zf;

    always_comb begin
        case (sel)
            CN_ALWAYS: hit = 1'b1;
            CN_LE:     hit = le;
            CN_LT:     hit = lt;
            CN_EQ:     hit = f.zf;
            CN_NE:     hit = ~f.zf;
            CN_GE:     hit = ~lt;
            CN_GT:     hit = ~le;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [FN_W-1:0]     alu_fn,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic                cc_load,
    input  logic [COND_W-1:0]   cond_fn,
    output logic [DATA_W-1:0]   result,
    output logic                zf,
    output logic                sf,
    output logic                of,
    output logic                cond_true
);
    flags_t next_flags;
    flags_t cur_flags;

    alu_core #(.W(DATA_W)) u_core (
        .op     (alu_op_e'(alu_fn)),
        .a      (opnd_a),
        .b      (opnd_b),
        .res    (result),
        .nflags (next_flags)
    );

    cc_reg u_cc (
        .clk  (clk),
        .rst  (rst),
        .load (cc_load),
        .d    (next_flags),
        .q    (cur_flags)
    );

    cond_eval u_cond (
        .f   (cur_flags),
        .sel (cond_fn),
        .hit (cond_true)
    );

    assign zf = cur_flags.zf;
    assign sf = cur_flags.sf;
    assign of = cur_flags.of;

endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  alu_fn,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        cc_load,
    input logic [3:0]  cond_fn,
    input logic [31:0] result,
    input logic        zf,
    input logic        sf,
    input logic        of,
    input logic        cond_true
);
    a_r4_reset_flags: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (zf && !sf && !of));

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        cc_load |=> (zf == ($past(result) == 32'd0)));

    a_r5_sign_flag: assert property (@(posedge clk) disable iff (rst)
        cc_load |=> (sf == $past(result[31])));

    a_r6_add_overflow: assert property (@(posedge clk) disable iff (rst)
        (cc_load && alu_fn == 2'd0) |=>
        (of == (($past(opnd_a[31]) == $past(opnd_b[31])) &&
                ($past(result[31]) != $past(opnd_a[31])))));

    a_r7_sub_overflow: assert property (@(posedge clk) disable iff (rst)
        (cc_load && alu_fn == 2'd1) |=>
        (of == (($past(opnd_a[31]) != $past(opnd_b[31])) &&
                ($past(result[31]) != $past(opnd_b[31])))));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cc_load && alu_fn[1]) |=> !of);

    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !cc_load |=> $stable({zf, sf, of}));

    a_r10_always: assert property (@(posedge clk) disable iff (rst)
        (cond_fn == 4'd0) |-> cond_true);

    a_r12_bad_code: assert property (@(posedge clk) disable iff (rst)
        (cond_fn >= 4'd7) |-> !cond_true);
endmodule

bind alu_cc_unit alu_cc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_fn    (alu_fn),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cc_load   (cc_load),
    .cond_fn   (cond_fn),
    .result    (result),
    .zf        (zf),
    .sf        (sf),
    .of        (of),
    .cond_true (cond_true)
);

// File: tb/sim_alu_cc_unit.sv
`timescale 1ns/1ps
module sim_alu_cc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  alu_fn = 2'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic        cc_load = 1'b0;
    logic [3:0]  cond_fn = 4'd0;
    logic [31:0] result;
    logic        zf, sf, of, cond_true;

    int checks = 0;
    int failures = 0;
    logic ez = 1'b1, es = 1'b0, eo = 1'b0;

    always #5 clk = ~clk;

    alu_cc_unit u0 (
        .clk(clk), .rst(rst), .alu_fn(alu_fn), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .cc_load(cc_load), .cond_fn(cond_fn),
        .result(result), .zf(zf), .sf(sf), .of(of), .cond_true(cond_true)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic ref_cond(input logic [3:0] c, input logic z,
                                      input logic s, input logic o);
        logic lt = s ^ o;
        case (c)
            4'd0: return 1'b1;
            4'd1: return lt | z;
            4'd2: return lt;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !lt;
            4'd6: return !(lt | z);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_flags(input string rz, input string ro);
        check(rz, "zf", {31'd0, zf}, {31'd0, ez});
        check(rz, "sf", {31'd0, sf}, {31'd0, es});
        check(ro, "of", {31'd0, of}, {31'd0, eo});
    endtask

    // apply one operation; result checked same cycle, flags after the edge
    task automatic do_op(input logic [1:0] fn, input logic [31:0] a,
                         input logic [31:0] b, input logic ld, input string req);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint full = 0;
        logic [31:0] er;
        logic ovf = 1'b0;
        case (fn)
            2'd0: full = sb + sa;
            2'd1: full = sb - sa;
            default: full = 0;
        endcase
        if (fn == 2'd0 || fn == 2'd1) begin
            er  = full[31:0];
            ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        end else if (fn == 2'd2) er = b & a;
        else er = b ^ a;
        @(negedge clk);
        alu_fn = fn; opnd_a = a; opnd_b = b; cc_load = ld;
        #1 check(req, "result", result, er);
        @(posedge clk);
        #1 cc_load = 1'b0;
        if (ld) begin
            ez = (er == 32'd0); es = er[31]; eo = ovf;
            check_flags("R5", fn == 2'd0 ? "R6" : (fn == 2'd1 ? "R7" : "R8"));
        end else begin
            check_flags("R9", "R9");
        end
    endtask

    task automatic sweep_conds();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cond_fn = 4'(c);
            #1 check((c == 0 || c == 3 || c == 4) ? "R10" :
                     (c >= 7 ? "R12" : "R11"),
                     $sformatf("cond_true code %0d", c),
                     {31'd0, cond_true}, {31'd0, ref_cond(4'(c), ez, es, eo)});
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        ez = 1'b1; es = 1'b0; eo = 1'b0;
        check_flags("R4", "R4");
        sweep_conds();
    endtask

    task automatic t_add();
        do_op(2'd0, 32'd7, 32'd5, 1'b1, "R1");
        do_op(2'd0, 32'd1, 32'h7fffffff, 1'b1, "R1");
        sweep_conds();
        do_op(2'd0, 32'h80000000, 32'h80000000, 1'b1, "R1");
        sweep_conds();
        do_op(2'd0, 32'hffffffff, 32'h00000001, 1'b1, "R1");
        do_op(2'd0, 32'hfffffff0, 32'h00000003, 1'b1, "R1");
        sweep_conds();
    endtask

    task automatic t_sub();
        do_op(2'd1, 32'd5, 32'd5, 1'b1, "R2");
        do_op(2'd1, 32'd9, 32'd4, 1'b1, "R2");
        do_op(2'd1, 32'd1, 32'h80000000, 1'b1, "R2");
        sweep_conds();
        do_op(2'd1, 32'h80000000, 32'd0, 1'b1, "R2");
        do_op(2'd1, 32'd3, 32'd100, 1'b1, "R2");
        sweep_conds();
    endtask

    task automatic t_logic();
        do_op(2'd0, 32'd1, 32'h7fffffff, 1'b1, "R1");
        do_op(2'd2, 32'hf0f0f0f0, 32'hff00ff00, 1'b1, "R3");
        do_op(2'd0, 32'd1, 32'h7fffffff, 1'b1, "R1");
        do_op(2'd3, 32'h12345678, 32'h12345678, 1'b1, "R3");
        do_op(2'd3, 32'h0000ffff, 32'h8000ff00, 1'b1, "R3");
    endtask

    task automatic t_hold();
        do_op(2'd1, 32'd2, 32'd1, 1'b1, "R2");
        do_op(2'd0, 32'd0, 32'd0, 1'b0, "R9");
        do_op(2'd0, 32'd1, 32'h7fffffff, 1'b0, "R9");
        do_op(2'd3, 32'h55, 32'haa, 1'b0, "R9");
        sweep_conds();
    endtask

    task automatic t_comb_cond();
        // R13: cond_true reflects freshly loaded flags with no further edge
        @(negedge clk);
        cond_fn = 4'd3;
        alu_fn = 2'd1; opnd_a = 32'd8; opnd_b = 32'd8; cc_load = 1'b1;
        @(posedge clk);
        #1 cc_load = 1'b0;
        check("R13", "cond_true after load", {31'd0, cond_true}, 32'd1);
        ez = 1'b1; es = 1'b0; eo = 1'b0;
        @(negedge clk);
        cond_fn = 4'd4;
        #1 check("R13", "cond_true on code change", {31'd0, cond_true}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_hold();
        t_comb_cond();
        do_op(2'd1, 32'd1, 32'd0, 1'b1, "R2");
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule